// File: doc/BRIEF.md
# Streaming Life Generation Engine

This block computes one generation step of Conway's Game of Life for a rectangular array whose rows are W cells wide. Rows enter top to bottom, one word per handshake, and the result for each row leaves on a second handshake in the same order. The block holds a three-row window, made of the row above, the current row and the incoming row below. It derives the next state of every cell in the current row in a single pass.

Each row in the window is widened by one dead edge bit at each end. A vertical bitwise adder folds the three rows into a two-plane column sum. A horizontal adder merges neighbouring columns into a four-plane count, 0 to 9, that includes the cell itself. The rule is then applied to every bit position at once. The time per row therefore does not depend on how many cells are alive. A frame is closed by flagging its last input row. The block then emits one extra result, for that last row, with a dead row assumed below it, and clears the window for the next frame.

Top module: `life_row_stream`

## Requirements
- R1: A cell of the next generation is alive when exactly 3 of its 8 neighbours are alive, or when it is alive now and exactly 2 neighbours are alive; every other cell is dead. Bit i of a row word is column i.
- R2: Cells outside the array are dead. This covers the columns left of bit 0 and right of bit W-1, the row above the first row of a frame and the row below its last row.
- R3: A frame of H input rows yields exactly H output rows, in input order. The result for row r is presented only after row r+1 has been accepted, or after row r was accepted with in_last high.
- R4: out_last is high on the result of the last row of a frame and low on every other result.
- R5: While out_valid is high and out_ready is low, out_valid, out_row and out_last hold their values, and no result is lost or duplicated.
- R6: in_ready is low while a result is held by backpressure. It is also low in the cycle after a row with in_last high is accepted, while the final result of the frame is being formed.
- R7: After reset, out_valid is 0 and in_ready is 1.
- R8: A frame of a single row (in_last on the first row) yields one result, computed with dead rows above and below.
- R9: With in_valid and out_ready held high, rows are accepted one per cycle. The last result of an H-row frame is taken H+1 cycles after the first row is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input row is offered |
| in_ready | output | 1 | The block takes the offered row at this edge |
| in_row | input | W | Current-generation row, bit i = column i, 1 = alive |
| in_last | input | 1 | The offered row is the bottom row of its frame |
| out_valid | output | 1 | A result row is offered |
| out_ready | input | 1 | The consumer takes the result at this edge |
| out_row | output | W | Next-generation row, bit i = column i |
| out_last | output | 1 | The result belongs to the bottom row of the frame |

## Verification
The bench builds the block with W = 12 and frames of 1 to 16 rows. Twelve columns leave room for a glider to travel four generations clear of both edge columns. They are also few enough that random fills regularly put live cells on columns 0 and 11 and on the top and bottom rows, which stresses the dead-border handling. Short frames of one and two rows exercise the flush path next to the first-row path. Random stalls on both handshakes cover the backpressure path.

// File: rtl/life_pkg.sv
package life_pkg;

  typedef enum logic [1:0] {
    WIN_EMPTY  = 2'd0,
    WIN_PRIMED = 2'd1,
    WIN_FLUSH  = 2'd2
  } win_state_e;

  // Rule on a 3x3 sum that includes the centre cell itself.
  function automatic logic cell_next(input logic [3:0] sum9, input logic self_alive);
    return (sum9 == 4'd3) || (self_alive && (sum9 == 4'd4));
  endfunction

endpackage

// File: rtl/life_colsum.sv
module life_colsum #(
  parameter int N = 10
) (
  input  logic [N-1:0] row_a,
  input  logic [N-1:0] row_b,
  input  logic [N-1:0] row_c,
  output logic [N-1:0] sum_lo,
  output logic [N-1:0] sum_hi
);
  // Bitwise full adder: per column, sum of three cells as two planes.
  function automatic logic [2*N-1:0] fa3(input logic [N-1:0] a,
                                         input logic [N-1:0] b,
                                         input logic [N-1:0] c);
    return {(a & b) | (a & c) | (b & c), a ^ b ^ c};
  endfunction

  assign {sum_hi, sum_lo} = fa3(row_a, row_b, row_c);
endmodule

// File: rtl/life_hsum.sv
module life_hsum #(
  parameter int W = 8,
  localparam int WE = W + 2
) (
  input  logic [WE-1:0]     col_lo,
  input  logic [WE-1:0]     col_hi,
  output logic [3:0][W-1:0] cnt_pl
);
  logic [W-1:0] l_left, l_mid, l_right, h_left, h_mid, h_right;
  logic [W-1:0] a0, a1, b0, b1, carry4;

  assign l_left  = col_lo[W-1:0];
  assign l_mid   = col_lo[W:1];
  assign l_right = col_lo[W+1:2];
  assign h_left  = col_hi[W-1:0];
  assign h_mid   = col_hi[W:1];
  assign h_right = col_hi[W+1:2];

  // weight-1 planes of the three column sums
  assign a0 = l_left ^ l_mid ^ l_right;
  assign a1 = (l_left & l_mid) | (l_left & l_right) | (l_mid & l_right);
  // weight-2 planes of the three column sums
  assign b0 = h_left ^ h_mid ^ h_right;
  assign b1 = (h_left & h_mid) | (h_left & h_right) | (h_mid & h_right);

  assign carry4    = a1 & b0;
  assign cnt_pl[0] = a0;
  assign cnt_pl[1] = a1 ^ b0;
  assign cnt_pl[2] = b1 ^ carry4;
  assign cnt_pl[3] = b1 & carry4;
endmodule

// File: rtl/life_rule.sv
module life_rule #(
  parameter int W = 8
) (
  input  logic [3:0][W-1:0] cnt_pl,
  input  logic [W-1:0]      center,
  output logic [W-1:0]      nxt
);
  import life_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_cell
    assign nxt[i] = cell_next({cnt_pl[3][i], cnt_pl[2][i], cnt_pl[1][i], cnt_pl[0][i]},
                              center[i]);
  end
endmodule

// File: rtl/life_gen_core.sv
module life_gen_core #(
  parameter int W = 8,
  localparam int WE = W + 2
) (
  input  logic [WE-1:0] above_x,
  input  logic [WE-1:0] center_x,
  input  logic [WE-1:0] below_x,
  output logic [W-1:0]  nxt
);
  logic [WE-1:0]     col_lo, col_hi;
  logic [3:0][W-1:0] cnt_pl;

  life_colsum #(.N(WE)) u_colsum (
    .row_a (above_x),
    .row_b (center_x),
    .row_c (below_x),
    .sum_lo(col_lo),
    .sum_hi(col_hi)
  );

  life_hsum #(.W(W)) u_hsum (
    .col_lo(col_lo),
    .col_hi(col_hi),
    .cnt_pl(cnt_pl)
  );

  life_rule #(.W(W)) u_rule (
    .cnt_pl(cnt_pl),
    .center(center_x[W:1]),
    .nxt   (nxt)
  );
endmodule

// File: rtl/life_row_stream.sv
module life_row_stream #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_row,
  input  logic         in_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_row,
  output logic         out_last
);
  import life_pkg::*;

  localparam int WE = W + 2;

  win_state_e   state_q;
  logic [W-1:0] top_q, mid_q;
  logic         out_valid_q, out_last_q;
  logic [W-1:0] out_row_q;

  // named events for the checker
  logic         slot_free, in_fire, flush_evt, emit_evt;
  logic [W-1:0] win_top, win_mid, win_bot, nxt_row;

  assign slot_free = !out_valid_q || out_ready;
  assign in_ready  = slot_free && (state_q != WIN_FLUSH);
  assign in_fire   = in_valid && in_ready;
  assign flush_evt = slot_free && (state_q == WIN_FLUSH);
  assign emit_evt  = (in_fire && (state_q == WIN_PRIMED)) || flush_evt;

  assign win_top = top_q;
  assign win_mid = mid_q;
  assign win_bot = flush_evt ? '0 : in_row;

  life_gen_core #(.W(W)) u_core (
    .above_x ({1'b0, win_top, 1'b0}),
    .center_x({1'b0, win_mid, 1'b0}),
    .below_x ({1'b0, win_bot, 1'b0}),
    .nxt     (nxt_row)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_EMPTY;
      top_q   <= '0;
      mid_q   <= '0;
    end else if (flush_evt) begin
      state_q <= WIN_EMPTY;
      top_q   <= '0;
      mid_q   <= '0;
    end else if (in_fire) begin
      top_q   <= (state_q == WIN_PRIMED) ? mid_q : '0;
      mid_q   <= in_row;
      state_q <= in_last ? WIN_FLUSH : WIN_PRIMED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_last_q  <= 1'b0;
      out_row_q   <= '0;
    end else if (emit_evt) begin
      out_valid_q <= 1'b1;
      out_last_q  <= flush_evt;
      out_row_q   <= nxt_row;
    end else if (out_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid = out_valid_q;
  assign out_row   = out_row_q;
  assign out_last  = out_last_q;

  logic unused_we;
  assign unused_we = (WE > 0);
endmodule

// File: rtl/life_row_stream_chk.sv
module life_row_stream_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_last,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_row,
  input logic         out_last,
  input logic         emit_evt,
  input logic         flush_evt,
  input logic [W-1:0] win_top,
  input logic [W-1:0] win_mid,
  input logic [W-1:0] win_bot
);
  assert_dead_stays_dead_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_evt && win_top == '0 && win_mid == '0 && win_bot == '0) |=> (out_row == '0));

  assert_result_after_emit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(emit_evt));

  assert_last_on_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> (out_valid && out_last));

  assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_last)));

  assert_no_take_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_flush_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);
endmodule

bind life_row_stream life_row_stream_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_last  (in_last),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_row  (out_row),
  .out_last (out_last),
  .emit_evt (emit_evt),
  .flush_evt(flush_evt),
  .win_top  (win_top),
  .win_mid  (win_mid),
  .win_bot  (win_bot)
);

// File: tb/life_row_stream_tb.sv
`timescale 1ns/1ps
module life_row_stream_tb;
  localparam int W    = 12;
  localparam int MAXH = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_row = '0;
  logic         in_last = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_row;
  logic         out_last;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [W-1:0] src  [MAXH];
  logic [W-1:0] got  [MAXH];
  logic         gotl [MAXH];
  int           ngot;
  int           frame_cycles;

  always #4 clk = ~clk;

  life_row_stream #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row), .out_last(out_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scalar reference: 8-neighbour count, dead outside the array.
  function automatic logic [W-1:0] ref_row(input int nrows, input int r);
    logic [W-1:0] res = '0;
    for (int c = 0; c < W; c++) begin
      int n = 0;
      for (int dr = -1; dr <= 1; dr++)
        for (int dc = -1; dc <= 1; dc++) begin
          int rr = r + dr;
          int cc = c + dc;
          if ((dr != 0 || dc != 0) && rr >= 0 && rr < nrows && cc >= 0 && cc < W)
            n += int'(src[rr][cc]);
        end
      res[c] = (n == 3) || (src[r][c] && n == 2);
    end
    return res;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // mode 0: always valid / ready; mode 1: random gaps on both sides
  task automatic run_frame(input int nrows, input int mode);
    int sent = 0;
    int guard = 0;
    ngot = 0;
    while (ngot < nrows && guard < 2000) begin
      @(negedge clk);
      in_valid  = (sent < nrows) && (mode == 0 || $urandom_range(0, 3) != 0);
      in_row    = (sent < nrows) ? src[sent] : '0;
      in_last   = (sent == nrows - 1);
      out_ready = (mode == 0) || ($urandom_range(0, 2) != 0);
      #1;
      if (in_valid && in_ready) sent++;
      if (out_valid && out_ready) begin
        got[ngot]  = out_row;
        gotl[ngot] = out_last;
        ngot++;
      end
      guard++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
    frame_cycles = guard;
    check("R3 row count", ngot, nrows);
  endtask

  task automatic check_frame(input int nrows);
    for (int r = 0; r < nrows && r < ngot; r++) begin
      check($sformatf("R1/R2 row %0d", r), got[r], ref_row(nrows, r));
      check($sformatf("R4 last flag row %0d", r), gotl[r], (r == nrows - 1));
    end
  endtask

  task automatic advance(input int nrows);
    for (int r = 0; r < nrows; r++) src[r] = got[r];
  endtask

  task automatic test_reset();
    do_reset();
    check("R7 out_valid after reset", out_valid, 1'b0);
    check("R7 in_ready after reset", in_ready, 1'b1);
  endtask

  task automatic test_blinker();
    for (int r = 0; r < 8; r++) src[r] = '0;
    src[2] = 12'h020; src[3] = 12'h020; src[4] = 12'h020;
    run_frame(8, 0);
    check_frame(8);
    check("R1 blinker turns horizontal", got[3], 12'h070);
    check("R1 blinker rows above cleared", got[2], 12'h000);
    check("R9 frame cycles", frame_cycles, 8 + 2);
    advance(8);
    run_frame(8, 1);
    check_frame(8);
    check("R1 blinker back to vertical", got[2] & got[3] & got[4], 12'h020);
  endtask

  task automatic test_glider();
    logic [W-1:0] orig [MAXH];
    for (int r = 0; r < 12; r++) src[r] = '0;
    src[0] = 12'b010; src[1] = 12'b100; src[2] = 12'b111;
    for (int r = 0; r < 12; r++) orig[r] = src[r];
    for (int g = 0; g < 4; g++) begin
      run_frame(12, g % 2);
      check_frame(12);
      advance(12);
    end
    for (int r = 0; r < 12; r++)
      check($sformatf("R1 glider shift row %0d", r), src[r],
            (r == 0) ? '0 : (orig[r-1] << 1));
  endtask

  task automatic test_edges();
    for (int r = 0; r < 5; r++) src[r] = '1;
    run_frame(5, 0);
    check_frame(5);
    check("R2 corner of full block", got[0], 12'h801);
    src[0] = 12'h801; src[1] = 12'h801; src[2] = 12'h000;
    run_frame(3, 0);
    check_frame(3);
    check("R2 two-row pair at edges dies", got[0], 12'h000);
  endtask

  task automatic test_single_row();
    src[0] = 12'h00e;
    run_frame(1, 0);
    check_frame(1);
    check("R8 single row keeps only middle", got[0], 12'h004);
    check("R8 single row last flag", gotl[0], 1'b1);
    check("R9 single row cycles", frame_cycles, 1 + 2);
  endtask

  task automatic test_random();
    for (int f = 0; f < 20; f++) begin
      int h = $urandom_range(1, MAXH);
      for (int r = 0; r < h; r++) src[r] = W'($urandom);
      run_frame(h, f % 2);
      check_frame(h);
    end
  endtask

  task automatic test_stall();
    src[0] = 12'h0f0; src[1] = 12'h0f0; src[2] = 12'h000;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_row = src[0]; in_last = 1'b0;
    @(negedge clk);
    in_row = src[1];
    @(negedge clk);
    in_row = src[2]; in_last = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1;
      check("R5 held valid", out_valid, 1'b1);
      check("R5 held row", out_row, ref_row(3, 0));
      check("R5 held last", out_last, 1'b0);
      check("R6 ready low under stall", in_ready, 1'b0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1;
    check("R6 ready back when slot frees", in_ready, 1'b1);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    #1;
    check("R5 row 1 after release", out_row, ref_row(3, 1));
    check("R6 flush bubble", in_ready, 1'b0);
    @(negedge clk);
    #1;
    check("R4 last row emitted", out_last, 1'b1);
    check("R3 last row value", out_row, ref_row(3, 2));
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_blinker();
        test_glider();
        test_edges();
        test_single_row();
        test_stall();
        test_random();
      end
      begin
        while (cyc < 100000) @(posedge clk) cyc++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule